// File: doc/BRIEF.md
# Cascadable Synchronous Counter Stage

This block is one stage of a wide synchronous counter. It holds a small count that steps by one on a rising clock edge, but only when both of its enable inputs are high. One enable, `enPar`, is meant to be shared by every stage of a chain. The other, `enTrk`, receives the carry from the stage below. The stage raises `termCnt` while it holds its highest value and `enTrk` is high. Because `termCnt` ignores `enPar`, wiring each stage's `termCnt` to the next stage's `enTrk` builds a counter of any width. All stages share one clock line and need no external gates.

Parameters select the modulus: decade mode wraps after 9, binary mode wraps after the all-ones value. Another parameter makes the active-low clear either asynchronous or synchronous. An active-low synchronous load copies a parallel value into the counter. A MOD-N sequence is formed by loading or clearing back to zero once a chosen value is reached.

Top module: `cascade_counter_stage`

## Requirements
- R1: With `clearN` and `loadN` high, the count steps by one on a clock edge only when `enPar` and `enTrk` are both high. Otherwise it keeps its value.
- R2: The highest value is 9 when `DECADE`=1 and 2^WIDTH-1 when `DECADE`=0. A count step from the highest value, or from any loaded value above it, gives 0.
- R3: `termCnt` is high exactly when the count equals the highest value and `enTrk` is high. `enPar` has no effect on it.
- R4: `termCnt` is low whenever `enTrk` is low, even at the highest value.
- R5: With `clearN` high and `loadN` low, the next clock edge copies `loadVal` into the count, whatever the enables are.
- R6: With `ASYNC_CLEAR`=1, a low `clearN` sets the count to 0 at once, without waiting for a clock edge. With `ASYNC_CLEAR`=0, it sets the count to 0 at the next clock edge and leaves the count unchanged until then. In both modes clear wins over load.
- R7: Three decade stages can be chained: each `termCnt` drives the next stage's `enTrk`, and the clock, `enPar`, `loadN` and `clearN` are shared. The chain then counts 000 to 999 and wraps to 000.
- R8: Pulling `loadN` low with `loadVal`=0 while the count equals 6 gives a repeating MOD-7 sequence 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by every stage of a chain |
| clearN | input | 1 | Active-low clear; asynchronous or synchronous depending on `ASYNC_CLEAR` |
| loadN | input | 1 | Active-low synchronous parallel load |
| enPar | input | 1 | Parallel count enable, shared by all stages |
| enTrk | input | 1 | Trickle count enable; also qualifies `termCnt` |
| loadVal | input | WIDTH | Value copied into the count during a load |
| count | output | WIDTH | Present count |
| termCnt | output | 1 | Terminal count, high at the highest value while `enTrk` is high |

## Verification
The assertions check on every clock cycle, for each stage, the behaviour that a single stage decides by itself:
- holding and stepping under the two enables;
- wrapping from the highest value;
- taking the load value;
- the exact condition for `termCnt`, including that it stays low while `enTrk` is low.

Some behaviours appear only in the bench's scenarios, which compare every stage against a behavioural model:
- a clear taking effect between clock edges;
- the difference between asynchronous and synchronous clear;
- a carry rippling through three chained stages from 999 back to 000;
- a MOD-7 loop built from the load input.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

  // Strobes from the control module to the datapath, one clock cycle each.
  typedef struct packed {
    logic clearNow;  // synchronous clear in this cycle
    logic loadNow;   // parallel load in this cycle
    logic countNow;  // count step in this cycle
  } stageStrobe_t;

endpackage

// File: rtl/cascade_counter_ctrl.sv
module cascade_counter_ctrl
  import cascade_counter_pkg::*;
#(
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic         clearN,
  input  logic         loadN,
  input  logic         enPar,
  input  logic         enTrk,
  input  logic         atMax,
  output stageStrobe_t strobe,
  output logic         asyncClrN,
  output logic         termCnt
);

  logic syncClear;

  // The clear style is picked by parameter.
  generate
    if (ASYNC_CLEAR) begin : g_asyncClear
      assign asyncClrN = clearN;
      assign syncClear = 1'b0;
    end else begin : g_syncClear
      assign asyncClrN = 1'b1;
      assign syncClear = ~clearN;
    end
  endgenerate

  // Priority: clear first, then load, then count.
  always_comb begin
    strobe.clearNow = syncClear;
    strobe.loadNow  = clearN & ~loadN;
    strobe.countNow = clearN & loadN & enPar & enTrk;
  end

  // The carry out depends only on the trickle enable, so it can feed the next stage.
  assign termCnt = enTrk & atMax;

endmodule

// File: rtl/cascade_counter_datapath.sv
module cascade_counter_datapath
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MAX_VAL = 9
) (
  input  logic             clk,
  input  logic             asyncClrN,
  input  stageStrobe_t     strobe,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] count,
  output logic             atMax
);

  localparam logic [WIDTH-1:0] MAX_V = WIDTH'(MAX_VAL);

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] nextVal;

  // A count at or above the highest value wraps to zero.
  always_comb begin
    if (countQ >= MAX_V) nextVal = '0;
    else                 nextVal = countQ + 1'b1;
  end

  always_ff @(posedge clk or negedge asyncClrN) begin
    if (!asyncClrN)           countQ <= '0;
    else if (strobe.clearNow) countQ <= '0;
    else if (strobe.loadNow)  countQ <= loadVal;
    else if (strobe.countNow) countQ <= nextVal;
  end

  assign count = countQ;
  assign atMax = (countQ == MAX_V);

endmodule

// File: rtl/cascade_counter_stage.sv
module cascade_counter_stage
  import cascade_counter_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b1,
  parameter bit ASYNC_CLEAR = 1'b1
) (
  input  logic             clk,
  input  logic             clearN,
  input  logic             loadN,
  input  logic             enPar,
  input  logic             enTrk,
  input  logic [WIDTH-1:0] loadVal,
  output logic [WIDTH-1:0] count,
  output logic             termCnt
);

  localparam int MAX_VAL = DECADE ? 9 : (2 ** WIDTH) - 1;

  stageStrobe_t strobe;
  logic         asyncClrN;
  logic         atMax;

  cascade_counter_ctrl #(
    .ASYNC_CLEAR(ASYNC_CLEAR)
  ) u_ctrl (
    .clearN   (clearN),
    .loadN    (loadN),
    .enPar    (enPar),
    .enTrk    (enTrk),
    .atMax    (atMax),
    .strobe   (strobe),
    .asyncClrN(asyncClrN),
    .termCnt  (termCnt)
  );

  cascade_counter_datapath #(
    .WIDTH  (WIDTH),
    .MAX_VAL(MAX_VAL)
  ) u_datapath (
    .clk      (clk),
    .asyncClrN(asyncClrN),
    .strobe   (strobe),
    .loadVal  (loadVal),
    .count    (count),
    .atMax    (atMax)
  );

endmodule

// File: rtl/cascade_counter_stage_chk.sv
module cascade_counter_stage_chk #(
  parameter int WIDTH   = 4,
  parameter int MAX_VAL = 9
) (
  input logic             clk,
  input logic             clearN,
  input logic             loadN,
  input logic             enPar,
  input logic             enTrk,
  input logic [WIDTH-1:0] loadVal,
  input logic [WIDTH-1:0] count,
  input logic             termCnt
);

  localparam logic [WIDTH-1:0] MAX_V = WIDTH'(MAX_VAL);

  a_r1_hold: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && !(enPar && enTrk)) |=> (count == $past(count)));

  a_r1_step: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && enPar && enTrk && (count < MAX_V)) |=> (count == $past(count) + 1'b1));

  a_r2_wrap: assert property (@(posedge clk) disable iff (!clearN)
    (loadN && enPar && enTrk && (count >= MAX_V)) |=> (count == '0));

  a_r3_tc_only_at_max: assert property (@(posedge clk) disable iff (!clearN)
    termCnt |-> ((count == MAX_V) && enTrk));

  a_r3_tc_at_max: assert property (@(posedge clk) disable iff (!clearN)
    (enTrk && (count == MAX_V)) |-> termCnt);

  a_r4_tc_low: assert property (@(posedge clk) disable iff (!clearN)
    !enTrk |-> !termCnt);

  a_r5_load: assert property (@(posedge clk) disable iff (!clearN)
    !loadN |=> (count == $past(loadVal)));

endmodule

bind cascade_counter_stage cascade_counter_stage_chk #(
  .WIDTH  (WIDTH),
  .MAX_VAL(MAX_VAL)
) u_chk (.*);

// File: tb/test_cascade_counter_stage.sv
module test_cascade_counter_stage;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit running = 1'b0;

  // Three-stage decade chain with asynchronous clear.
  logic       cClrN = 1'b0, cLoadN = 1'b1, cEnP = 1'b0, cEnT = 1'b0;
  logic [3:0] cLv0 = '0, cLv1 = '0, cLv2 = '0;
  logic [3:0] q0, q1, q2;
  logic       tc0, tc1, tc2;

  // Binary stage with synchronous clear.
  logic       bClrN = 1'b0, bLoadN = 1'b1, bEnP = 1'b0, bEnT = 1'b0;
  logic [3:0] bLv = '0;
  logic [3:0] bQ;
  logic       bTc;

  cascade_counter_stage #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLEAR(1'b1)) i_cascade_counter_stage (
    .clk(clk), .clearN(cClrN), .loadN(cLoadN), .enPar(cEnP), .enTrk(cEnT),
    .loadVal(cLv0), .count(q0), .termCnt(tc0));
  cascade_counter_stage #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLEAR(1'b1)) i_stage1 (
    .clk(clk), .clearN(cClrN), .loadN(cLoadN), .enPar(cEnP), .enTrk(tc0),
    .loadVal(cLv1), .count(q1), .termCnt(tc1));
  cascade_counter_stage #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLEAR(1'b1)) i_stage2 (
    .clk(clk), .clearN(cClrN), .loadN(cLoadN), .enPar(cEnP), .enTrk(tc1),
    .loadVal(cLv2), .count(q2), .termCnt(tc2));
  cascade_counter_stage #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLEAR(1'b0)) i_binStage (
    .clk(clk), .clearN(bClrN), .loadN(bLoadN), .enPar(bEnP), .enTrk(bEnT),
    .loadVal(bLv), .count(bQ), .termCnt(bTc));

  // Behavioural reference model.
  int md[3];
  int mb;

  always @(posedge clk or negedge cClrN) begin
    if (!cClrN) begin
      for (int i = 0; i < 3; i++) md[i] = 0;
    end else if (!cLoadN) begin
      md[0] = cLv0; md[1] = cLv1; md[2] = cLv2;
    end else if (cEnP) begin
      bit t;
      t = cEnT;
      for (int i = 0; i < 3; i++) begin
        bit nt;
        nt = t && (md[i] == 9);
        if (t) md[i] = (md[i] >= 9) ? 0 : md[i] + 1;
        t = nt;
      end
    end
  end

  always @(posedge clk) begin
    if (!bClrN)              mb = 0;
    else if (!bLoadN)        mb = bLv;
    else if (bEnP && bEnT)   mb = (mb >= 15) ? 0 : mb + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every output against the model on every falling edge.
  always @(negedge clk) begin
    if (running) begin
      bit t;
      int tcs[3];
      t = cEnT;
      for (int i = 0; i < 3; i++) begin
        tcs[i] = (t && (md[i] == 9)) ? 1 : 0;
        t = tcs[i][0];
      end
      check("R1/R7 stage0 count", int'(q0), md[0]);
      check("R1/R7 stage1 count", int'(q1), md[1]);
      check("R1/R7 stage2 count", int'(q2), md[2]);
      check("R3/R4 stage0 termCnt", int'(tc0), tcs[0]);
      check("R3/R4 stage1 termCnt", int'(tc1), tcs[1]);
      check("R3/R4 stage2 termCnt", int'(tc2), tcs[2]);
      check("R2 binary count", int'(bQ), mb);
      check("R3 binary termCnt", int'(bTc), (bEnT && mb == 15) ? 1 : 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  function automatic int chainVal();
    return int'(q2) * 100 + int'(q1) * 10 + int'(q0);
  endfunction

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mb = 0;
    step(3);
    check("R6 reset chain", chainVal(), 0);
    check("R6 reset binary", int'(bQ), 0);
    cClrN = 1'b1; bClrN = 1'b1;
    running = 1'b1;

    // R7: chained count 000..999 and wrap
    cEnP = 1'b1; cEnT = 1'b1;
    step(999);
    check("R7 reach 999", chainVal(), 999);
    check("R3 top carry at 999", int'(tc2), 1);
    step(1);
    check("R7 wrap to 000", chainVal(), 0);
    step(37);
    check("R7 value 37", chainVal(), 37);

    // R1: hold when either enable is low
    cEnP = 1'b0;
    step(4);
    check("R1 hold enPar low", chainVal(), 37);
    cEnP = 1'b1; cEnT = 1'b0;
    step(4);
    check("R1 hold enTrk low", chainVal(), 37);

    // R5: load overrides count; R3/R4 at the highest value
    cLoadN = 1'b0; cLv0 = 4'd9; cLv1 = 4'd9; cLv2 = 4'd4;
    cEnT = 1'b1;
    step(1);
    cLoadN = 1'b1;
    check("R5 load 499", chainVal(), 499);
    cEnP = 1'b0;
    #1;
    check("R3 termCnt ignores enPar", int'(tc1), 1);
    cEnT = 1'b0;
    #1;
    check("R4 termCnt low with enTrk low", int'(tc0), 0);
    cEnT = 1'b1; cEnP = 1'b1;
    step(1);
    check("R7 carry 499 to 500", chainVal(), 500);

    // R2: decade stage loaded above 9 wraps to 0 without a carry
    cLoadN = 1'b0; cLv0 = 4'd12; cLv1 = 4'd3; cLv2 = 4'd0;
    step(1);
    cLoadN = 1'b1;
    step(1);
    check("R2 decade over-range wrap", chainVal(), 30);

    // R6: asynchronous clear takes effect between edges and wins over load
    step(5);
    @(negedge clk); #2;
    cClrN = 1'b0; cLoadN = 1'b0; cLv0 = 4'd7;
    #1;
    check("R6 async clear immediate", chainVal(), 0);
    step(2);
    check("R6 clear overrides load", chainVal(), 0);
    cClrN = 1'b1; cLoadN = 1'b1;

    // R2: binary wrap after 15
    bEnP = 1'b1; bEnT = 1'b1;
    step(15);
    check("R2 binary at 15", int'(bQ), 15);
    check("R3 binary termCnt at 15", int'(bTc), 1);
    bEnT = 1'b0;
    #1;
    check("R4 binary termCnt low", int'(bTc), 0);
    bEnT = 1'b1;
    step(1);
    check("R2 binary wrap to 0", int'(bQ), 0);

    // R6: synchronous clear waits for the clock edge
    step(5);
    bClrN = 1'b0;
    #1;
    check("R6 sync clear waits for edge", int'(bQ), 5);
    step(1);
    check("R6 sync clear at edge", int'(bQ), 0);
    bClrN = 1'b1;

    // R8: MOD-7 through load at 6
    bLv = 4'd0;
    for (int k = 0; k < 21; k++) begin
      bLoadN = (bQ == 4'd6) ? 1'b0 : 1'b1;
      check("R8 mod-7 sequence", int'(bQ), k % 7);
      step(1);
    end
    bLoadN = 1'b1;

    running = 1'b0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule